// File: doc/BRIEF.md
# SIMD Lane Shift and Bit-Manipulation Unit

This unit treats a 128-bit vector as a set of equal lanes and applies one per-lane operation to all of them at once. The lane width is chosen by a format select (8, 16, 32 or 64 bits), so the vector holds 16, 8, 4 or 2 lanes.

The operations fall into three groups:
- **Shifts:** plain shifts and rounding shifts.
- **Single-bit operations:** clear, set and flip.
- **Bit-field inserts:** these merge part of the source lane into the old destination lane.

Each lane takes its shift amount or bit index from the low bits of the matching lane of `wt`. That amount is therefore always reduced modulo the lane width.

The operation is combinational across all lanes. The result is captured in an output register on a clock edge where `in_valid` is high, and `out_valid` rises in the following cycle. The unit is meant to sit in the execute stage of a vector datapath. Instruction decode and register-file access are done by the surrounding logic.

Top module: `simd_bitops_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls with no input, `out_valid` is 0 and `out_vec` is all zeros.
- R2: A clock edge with `in_valid` high loads the result into `out_vec` and sets `out_valid`, both visible in the next cycle. A clock edge with `in_valid` low clears `out_valid` and leaves `out_vec` unchanged.
- R3: `fmt` selects the lane width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Lane i occupies bits [i*W+W-1 : i*W]. Each lane's amount n is the low log2(W) bits of its `wt` lane, which is the `wt` lane value modulo W.
- R4: Shifts. `op` 0 shifts the `ws` lane left by n. `op` 1 shifts it right by n with sign extension. `op` 2 shifts it right by n with zero fill.
- R5: Rounding shifts. `op` 3 is an arithmetic right shift and `op` 4 is a logical right shift. Each adds bit n-1 of the `ws` lane to the shifted value, and adds nothing when n is 0. The sum wraps within the lane.
- R6: Single-bit operations on the `ws` lane. `op` 5 clears bit n, `op` 6 sets bit n, and `op` 7 inverts bit n. All other bits pass through.
- R7: `op` 8 takes the top n+1 bits of the lane from `ws` and the low W-n-1 bits from `wd`. When n = W-1 the result is the `ws` lane.
- R8: `op` 9 takes the bottom n+1 bits of the lane from `ws` and the high W-n-1 bits from `wd`. When n = W-1 the result is the `ws` lane.
- R9: `op` codes 10 to 15 return `wd` unchanged in every lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| op | input | 4 | Operation code (see R4 to R9) |
| fmt | input | 2 | Lane width select (see R3) |
| wd | input | 128 | Old destination vector |
| ws | input | 128 | Source vector |
| wt | input | 128 | Per-lane shift amount or bit index vector |
| out_valid | output | 1 | `out_vec` holds a fresh result |
| out_vec | output | 128 | New destination vector |

## Verification
The bench sets `wt` lanes above the lane width, so a design that forgot the modulo would shift everything out or index outside the lane. It drives shift amounts of 0 and W-1 through the rounding shifts. A wrong round bit shows up there as an off-by-one result, or as a read of bit -1 when n is 0. It drives inserts with n = W-1, where a mask built as (1<<(n+1))-1 overflows and wipes the lane instead of copying `ws`. Random operands go through every code and format, so a lane boundary placed wrongly in any format corrupts a neighbouring lane.

// File: rtl/simd_bitops_pkg.sv
package simd_bitops_pkg;

    localparam int VEC_W   = 128;
    localparam int N_FMT   = 4;
    localparam int MIN_LW  = 8;

    typedef enum logic [1:0] {
        FMT_B8  = 2'd0,
        FMT_H16 = 2'd1,
        FMT_W32 = 2'd2,
        FMT_D64 = 2'd3
    } lane_fmt_e;

    typedef enum logic [3:0] {
        OP_SHL      = 4'd0,
        OP_SHRA     = 4'd1,
        OP_SHRL     = 4'd2,
        OP_SHRA_RND = 4'd3,
        OP_SHRL_RND = 4'd4,
        OP_BIT_CLR  = 4'd5,
        OP_BIT_SET  = 4'd6,
        OP_BIT_FLIP = 4'd7,
        OP_INS_TOP  = 4'd8,
        OP_INS_BOT  = 4'd9,
        OP_RSV_A    = 4'd10,
        OP_RSV_B    = 4'd11,
        OP_RSV_C    = 4'd12,
        OP_RSV_D    = 4'd13,
        OP_RSV_E    = 4'd14,
        OP_RSV_F    = 4'd15
    } lane_op_e;

    typedef struct packed {
        logic [VEC_W-1:0] wd;
        logic [VEC_W-1:0] ws;
        logic [VEC_W-1:0] wt;
    } vec_operands_t;

    function automatic int lane_width(input int fmt_idx);
        return MIN_LW << fmt_idx;
    endfunction

endpackage

// File: rtl/simd_lane_core.sv
module simd_lane_core
    import simd_bitops_pkg::*;
#(
    parameter int W = 8
) (
    input  lane_op_e       op,
    input  logic [W-1:0]   d,
    input  logic [W-1:0]   s,
    input  logic [W-1:0]   t,
    output logic [W-1:0]   r
);
    localparam int LW = $clog2(W);
    localparam logic [LW-1:0] TOPIDX = LW'(W - 1);

    logic [LW-1:0] n;
    logic [LW-1:0] nm1;
    logic          rbit;
    logic [W-1:0]  ones;
    logic [W-1:0]  onehot;
    logic [W-1:0]  mask_bot;
    logic [W-1:0]  mask_top;
    logic [W-1:0]  sh_l;
    logic [W-1:0]  sh_a;
    logic [W-1:0]  sh_r;

    always_comb begin
        n        = t[LW-1:0];
        nm1      = n - 1'b1;
        rbit     = (n != '0) && s[nm1];
        ones     = '1;
        onehot   = {{(W-1){1'b0}}, 1'b1} << n;
        mask_bot = ones >> (TOPIDX - n);
        mask_top = ones << (TOPIDX - n);
        sh_l     = s << n;
        sh_a     = W'($signed(s) >>> n);
        sh_r     = s >> n;
    end

    always_comb begin
        unique case (op)
            OP_SHL:      r = sh_l;
            OP_SHRA:     r = sh_a;
            OP_SHRL:     r = sh_r;
            OP_SHRA_RND: r = sh_a + W'(rbit);
            OP_SHRL_RND: r = sh_r + W'(rbit);
            OP_BIT_CLR:  r = s & ~onehot;
            OP_BIT_SET:  r = s | onehot;
            OP_BIT_FLIP: r = s ^ onehot;
            OP_INS_TOP:  r = (s & mask_top) | (d & ~mask_top);
            OP_INS_BOT:  r = (s & mask_bot) | (d & ~mask_bot);
            default:     r = d;
        endcase
    end
endmodule

// File: rtl/simd_fmt_slice.sv
module simd_fmt_slice
    import simd_bitops_pkg::*;
#(
    parameter int VW = 128,
    parameter int W  = 8
) (
    input  lane_op_e        op,
    input  vec_operands_t   opnd,
    output logic [VW-1:0]   res
);
    localparam int NL = VW / W;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        simd_lane_core #(.W(W)) u_lane (
            .op (op),
            .d  (opnd.wd[i*W +: W]),
            .s  (opnd.ws[i*W +: W]),
            .t  (opnd.wt[i*W +: W]),
            .r  (res[i*W +: W])
        );
    end
endmodule

// File: rtl/simd_bitops_unit.sv
module simd_bitops_unit
    import simd_bitops_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [3:0]         op,
    input  logic [1:0]         fmt,
    input  logic [VEC_W-1:0]   wd,
    input  logic [VEC_W-1:0]   ws,
    input  logic [VEC_W-1:0]   wt,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_vec
);
    vec_operands_t     opnd;
    lane_op_e          op_e;
    logic [VEC_W-1:0]  fmt_res [N_FMT];
    logic [VEC_W-1:0]  sel_res;

    assign opnd = '{wd: wd, ws: ws, wt: wt};
    assign op_e = lane_op_e'(op);

    for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
        simd_fmt_slice #(.VW(VEC_W), .W(lane_width(g))) u_slice (
            .op   (op_e),
            .opnd (opnd),
            .res  (fmt_res[g])
        );
    end

    assign sel_res = fmt_res[fmt];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec <= sel_res;
            end
        end
    end
endmodule

// File: rtl/simd_bitops_checker.sv
module simd_bitops_checker (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [3:0]   op,
    input logic [1:0]   fmt,
    input logic [127:0] wd,
    input logic [127:0] ws,
    input logic         out_valid,
    input logic [127:0] out_vec
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                             // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_vec)));                     // R2
    AST_SET_KEEPS_SRC: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'd6) |=> ((out_vec & $past(ws)) == $past(ws)));  // R6
    AST_CLR_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'd5) |=> ((out_vec & ~$past(ws)) == '0));        // R6
    AST_FLIP_ONE_PER_LANE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'd7) |=>
            ($countones(out_vec ^ $past(ws)) == (16 >> $past(fmt))));        // R6
    AST_RSV_PASSES_DEST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op >= 4'd10) |=> (out_vec == $past(wd)));               // R9
endmodule

bind simd_bitops_unit simd_bitops_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .fmt       (fmt),
    .wd        (wd),
    .ws        (ws),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/simd_bitops_unit_test.sv
module simd_bitops_unit_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [3:0]   op = '0;
    logic [1:0]   fmt = '0;
    logic [127:0] wd = '0, ws = '0, wt = '0;
    logic         out_valid;
    logic [127:0] out_vec;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [127:0] exp_q [$];
    string        tag_q [$];

    always #2 clk = ~clk;

    simd_bitops_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .fmt(fmt),
        .wd(wd), .ws(ws), .wt(wt), .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic logic [127:0] model(input logic [3:0] o, input logic [1:0] f,
                                           input logic [127:0] d, input logic [127:0] s,
                                           input logic [127:0] t);
        logic [127:0] res;
        int w, nl;
        res = '0;
        w  = 8 << f;
        nl = 128 / w;
        for (int i = 0; i < nl; i++) begin
            logic [63:0] msk, a, b, c, r, lo, hi, sx;
            int n, bits;
            msk = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
            a = 64'(s >> (i*w)) & msk;
            b = 64'(d >> (i*w)) & msk;
            c = 64'(t >> (i*w)) & msk;
            n = int'(c % 64'(w));
            sx = a[w-1] ? (a | ~msk) : a;
            bits = n + 1;
            lo = (bits == 64) ? {64{1'b1}} : ((64'd1 << bits) - 64'd1);
            hi = lo << (w - bits);
            case (o)
                4'd0: r = a << n;
                4'd1: r = 64'($signed(sx) >>> n);
                4'd2: r = a >> n;
                4'd3: r = 64'($signed(sx) >>> n) + ((n == 0) ? 64'd0 : ((a >> (n-1)) & 64'd1));
                4'd4: r = (a >> n) + ((n == 0) ? 64'd0 : ((a >> (n-1)) & 64'd1));
                4'd5: r = a & ~(64'd1 << n);
                4'd6: r = a | (64'd1 << n);
                4'd7: r = a ^ (64'd1 << n);
                4'd8: r = (a & hi) | (b & ~hi);
                4'd9: r = (a & lo) | (b & ~lo);
                default: r = b;
            endcase
            res = res | (128'(r & msk) << (i*w));
        end
        return res;
    endfunction

    function automatic string tag_of(input logic [3:0] o);
        if (o <= 4'd2) return "R4";
        if (o <= 4'd4) return "R5";
        if (o <= 4'd7) return "R6";
        if (o == 4'd8) return "R7";
        if (o == 4'd9) return "R8";
        return "R9";
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic drive(input logic [3:0] o, input logic [1:0] f, input logic [127:0] d,
                         input logic [127:0] s, input logic [127:0] t, input string req);
        @(negedge clk);
        in_valid = 1'b1; op = o; fmt = f; wd = d; ws = s; wt = t;
        exp_q.push_back(model(o, f, d, s, t));
        tag_q.push_back(req);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        ws = ~ws; wt = ~wt; wd = ~wd;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2", {127'd0, out_valid}, 128'd0);
                end else begin
                    logic [127:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = tag_q.pop_front();
                    check(r, out_vec, e);
                end
            end
        end
    end

    task automatic finish_up();
        if (exp_q.size() != 0) check("R2", 128'(exp_q.size()), 128'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        logic [127:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R1", {127'd0, out_valid}, 128'd0);      // R1 during reset
        check("R1", out_vec, 128'd0);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R1", {127'd0, out_valid}, 128'd0);      // R1 after release, no input
        check("R1", out_vec, 128'd0);

        // R3: amounts above the lane width wrap
        drive(4'd0, 2'd0, '0, {16{8'h81}}, {16{8'h0B}}, "R3");
        drive(4'd2, 2'd1, '0, {8{16'h8001}}, {8{16'h0013}}, "R3");
        drive(4'd1, 2'd2, '0, {4{32'h8000_0010}}, {4{32'hFFFF_FFE4}}, "R3");
        drive(4'd0, 2'd3, '0, {2{64'h0123_4567_89AB_CDEF}}, {2{64'h0000_0000_0000_0041}}, "R3");
        // R5 corners: n = 0 and n = W-1, wraparound
        drive(4'd3, 2'd0, '0, {16{8'h80}}, {16{8'h07}}, "R5");
        drive(4'd4, 2'd0, '0, {16{8'hFF}}, {16{8'h01}}, "R5");
        drive(4'd4, 2'd1, '0, {8{16'hFFFF}}, {8{16'h0000}}, "R5");
        drive(4'd3, 2'd3, '0, {2{64'h7FFF_FFFF_FFFF_FFFF}}, {2{64'd1}}, "R5");
        // R7 / R8 full-width and single-bit inserts
        drive(4'd8, 2'd0, {16{8'hAA}}, {16{8'h55}}, {16{8'h07}}, "R7");
        drive(4'd8, 2'd2, {4{32'h0000_FFFF}}, {4{32'hF0F0_0000}}, {4{32'd0}}, "R7");
        drive(4'd9, 2'd3, {2{64'hFFFF_FFFF_0000_0000}}, {2{64'h1234}}, {2{64'd63}}, "R8");
        drive(4'd9, 2'd1, {8{16'hFFFF}}, {8{16'h0000}}, {8{16'h0004}}, "R8");
        // R6 top-bit index
        drive(4'd7, 2'd3, '0, '0, {2{64'd63}}, "R6");

        // R2: idle cycle holds output
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); #1;
        held = out_vec;
        idle();
        @(negedge clk); #1;
        check("R2", {127'd0, out_valid}, 128'd0);
        check("R2", out_vec, held);

        // random sweep over every code and format
        for (int k = 0; k < 4; k++) begin
            for (int o = 0; o < 16; o++) begin
                for (int f = 0; f < 4; f++) begin
                    drive(4'(o), 2'(f),
                          {$urandom, $urandom, $urandom, $urandom},
                          {$urandom, $urandom, $urandom, $urandom},
                          {$urandom, $urandom, $urandom, $urandom},
                          tag_of(4'(o)));
                end
            end
        end
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_up();
    end
endmodule